// File: doc/BRIEF.md
# Radar Frame Power-State Sequencer

This block paces a pulsed-chirp radar front end through its frame. It produces chirps and groups them into bursts. After the last burst it runs a data-processing phase, then waits in an idle period until the frame period has elapsed. All lengths are programmed as cycle counts of the reference clock. Every phase has a fixed set of enable and clock-gate levels for five power domains: the RF analog front end, the front-end controller, the application processor, the accelerator and the always-on logic. The sequencer drives these levels directly, so the power controller only has to follow its outputs.

Each of the three idle gaps has a lower bound. The gap between chirps depends on the transmitter start time and on whether low-power modes are enabled. If a programmed gap is shorter than its bound, the bound is used instead and a sticky flag records the violation. A frame whose active part leaves too little room for the minimum idle before the next frame starts late and raises a sticky overrun flag. From the interframe idle, a request can send the device into deep sleep. The sequencer asks the software to prepare and waits for its acknowledgement before it removes power. It wakes on a sleep-counter expiry or on one of four external events and records which one caused the wake. It then asks for a restore and starts a new frame once the restore is acknowledged.

Top module: `rfps_seq`

## Requirements
- R1: After reset `phase` is 4 (interframe idle). `wake_src`, `viol_ichirp`, `viol_iburst`, `frame_overrun`, `pd_start` and `restore_req` are 0, and the power outputs show the interframe-idle levels given in R2.
- R2: `phase` encodes 0 chirp, 1 chirp gap, 2 burst gap, 3 processing, 4 interframe idle, 5 power-down wait, 6 sleep, 7 restore. The power outputs, in the order rf_on, rf_txrx_on, rf_xtal_on, fe_on, fe_dp_gate, fe_all_gate, app_on, app_xtal_clk, acc_on, acc_gate, aon_on, are: chirp 11110010111; chirp gap 10111010101; burst gap 00111010111; processing 00100010101; phases 4, 5 and 7 00111111001; sleep 00000000001.
- R3: A frame is `cfg_bursts` bursts of `cfg_chirps` chirps, each chirp lasting `cfg_chirp_len` cycles. Chirps in a burst are separated by a chirp gap, and bursts are separated by a burst gap. The last chirp is followed by `cfg_proc_len` cycles of processing and then by interframe idle. A count of 0 acts as 1.
- R4: The chirp gap lasts max(`cfg_ichirp_idle`, G) cycles. G = max(B − `cfg_tx_start`, F), where B is 6 µs when `cfg_lp_en` is 1 and 4 µs otherwise, and F is 3.1 µs. All three are converted with CYC_PER_US and rounded down, and B − tx is taken as 0 when tx ≥ B. Using a gap shorter than G sets the sticky `viol_ichirp`.
- R5: The burst gap lasts max(`cfg_iburst_idle`, 95 µs) cycles. Using a shorter programmed value sets the sticky `viol_iburst`.
- R6: `frame_start` is high in the first chirp cycle of each frame. When the active part of a frame (E cycles) plus 135 µs fits in `cfg_frame_period` (P), consecutive frame starts are exactly P cycles apart.
- R7: When E + 135 µs exceeds P, the next frame starts E + 135 µs cycles after the previous one, and the sticky `frame_overrun` is set.
- R8: Deep sleep is entered only when `sleep_req` is high during interframe idle. The next phase is then 5. `sleep_req` in any other phase has no effect. When `sleep_req` is high in the cycle in which the next frame would start, sleep wins and no frame starts.
- R9: In phase 5, `pd_start` is 1 and the phase holds until `pd_done` is 1. The next phase is then 6 (sleep).
- R10: Sleep ends after `cfg_sleep_len` cycles, or earlier on any `wake_evt` bit (bit 0 UART RX, 1 SPI chip select, 2 GPIO, 3 RTC). The next phase is 7. `wake_evt`, `pd_done` and `restore_done` have no effect outside phases 6, 5 and 7 respectively.
- R11: On wake, `wake_src` is loaded one-hot and holds until the next wake. Bit 0 is counter expiry and bits 1 to 4 are `wake_evt` bits 0 to 3. When several causes fall in the same cycle, the lowest bit wins.
- R12: In phase 7, `restore_req` is 1 until `restore_done` is 1. The next cycle is the first chirp of a new frame, with `frame_start` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_lp_en | input | 1 | Low-power modes enabled (selects chirp-gap base) |
| cfg_tx_start | input | TW | Transmitter start time in cycles |
| cfg_chirp_len | input | TW | Chirp length in cycles |
| cfg_ichirp_idle | input | TW | Programmed chirp gap in cycles |
| cfg_iburst_idle | input | TW | Programmed burst gap in cycles |
| cfg_proc_len | input | TW | Processing phase length in cycles |
| cfg_chirps | input | CW | Chirps per burst |
| cfg_bursts | input | CW | Bursts per frame |
| cfg_frame_period | input | FW | Frame period in cycles |
| cfg_sleep_len | input | TW | Sleep counter length in cycles |
| sleep_req | input | 1 | Request to enter deep sleep |
| pd_done | input | 1 | Power-down preparation finished |
| restore_done | input | 1 | Restore after wake finished |
| wake_evt | input | 4 | External wake events: UART RX, SPI CS, GPIO, RTC |
| phase | output | 3 | Current phase code |
| frame_start | output | 1 | First chirp cycle of a frame |
| rf_on | output | 1 | RF analog domain enabled |
| rf_txrx_on | output | 1 | Power and low-noise amplifiers enabled |
| rf_xtal_on | output | 1 | Crystal oscillator enabled |
| fe_on | output | 1 | Front-end controller domain enabled |
| fe_dp_gate | output | 1 | Front-end digital path clock gated |
| fe_all_gate | output | 1 | Whole front-end controller clock gated |
| app_on | output | 1 | Application domain enabled |
| app_xtal_clk | output | 1 | Application domain clocked from crystal |
| acc_on | output | 1 | Accelerator domain enabled |
| acc_gate | output | 1 | Accelerator clock gated |
| aon_on | output | 1 | Always-on domain enabled |
| pd_start | output | 1 | Ask software to prepare for power-down |
| restore_req | output | 1 | Ask software to restore after wake |
| wake_src | output | 5 | One-hot cause of the last wake |
| viol_ichirp | output | 1 | Sticky: chirp gap below minimum |
| viol_iburst | output | 1 | Sticky: burst gap below minimum |
| frame_overrun | output | 1 | Sticky: frame exceeded its period |

## Verification
Two events can fall in the same cycle and compete for the next phase. One is the launch of a new frame at the end of interframe idle. The other is a deep-sleep request. The bench counts P − 1 cycles from a frame start to reach the last idle cycle, raises `sleep_req` in exactly that cycle, and checks that the next phase is 5 with no `frame_start`. A second collision, two wake events in one sleep cycle, is judged by the one-hot value left in `wake_src`.

// File: rtl/rfps_pkg.sv
package rfps_pkg;

  typedef enum logic [2:0] {
    PH_CHIRP   = 3'd0,
    PH_ICHIRP  = 3'd1,
    PH_IBURST  = 3'd2,
    PH_PROC    = 3'd3,
    PH_IFRAME  = 3'd4,
    PH_PDWAIT  = 3'd5,
    PH_SLEEP   = 3'd6,
    PH_RESTORE = 3'd7
  } phase_e;

  typedef struct packed {
    logic rf_on;
    logic rf_txrx_on;
    logic rf_xtal_on;
    logic fe_on;
    logic fe_dp_gate;
    logic fe_all_gate;
    logic app_on;
    logic app_xtal_clk;
    logic acc_on;
    logic acc_gate;
    logic aon_on;
  } pwr_t;

  // Domain levels held in each phase.
  function automatic pwr_t phase_power(input phase_e ph);
    pwr_t p;
    p = '0;
    p.aon_on = 1'b1;
    unique case (ph)
      PH_CHIRP: begin
        p.rf_on = 1'b1; p.rf_txrx_on = 1'b1; p.rf_xtal_on = 1'b1;
        p.fe_on = 1'b1; p.app_on = 1'b1; p.acc_on = 1'b1; p.acc_gate = 1'b1;
      end
      PH_ICHIRP: begin
        p.rf_on = 1'b1; p.rf_xtal_on = 1'b1;
        p.fe_on = 1'b1; p.fe_dp_gate = 1'b1; p.app_on = 1'b1; p.acc_on = 1'b1;
      end
      PH_IBURST: begin
        p.rf_xtal_on = 1'b1; p.fe_on = 1'b1; p.fe_dp_gate = 1'b1;
        p.app_on = 1'b1; p.acc_on = 1'b1; p.acc_gate = 1'b1;
      end
      PH_PROC: begin
        p.rf_xtal_on = 1'b1; p.app_on = 1'b1; p.acc_on = 1'b1;
      end
      PH_SLEEP: begin
      end
      default: begin // interframe idle, power-down wait, restore
        p.rf_xtal_on = 1'b1; p.fe_on = 1'b1; p.fe_dp_gate = 1'b1;
        p.fe_all_gate = 1'b1; p.app_on = 1'b1; p.app_xtal_clk = 1'b1;
      end
    endcase
    return p;
  endfunction

  // Chirp-gap lower bound: max(base - tx, floor), base - tx clamped at 0.
  function automatic int unsigned chirp_gap_min(input logic lp,
                                                input int unsigned tx,
                                                input int unsigned lp_base,
                                                input int unsigned base,
                                                input int unsigned floor_v);
    int unsigned b;
    int unsigned d;
    b = lp ? lp_base : base;
    d = (tx >= b) ? 0 : (b - tx);
    return (d > floor_v) ? d : floor_v;
  endfunction

endpackage

// File: rtl/rfps_pwrmap.sv
module rfps_pwrmap
  import rfps_pkg::*;
(
  input  phase_e ph,
  output pwr_t   pwr
);
  always_comb pwr = phase_power(ph);
endmodule

// File: rtl/rfps_minchk.sv
module rfps_minchk
  import rfps_pkg::*;
#(
  parameter int TW         = 16,
  parameter int CYC_PER_US = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lp_en,
  input  logic [TW-1:0] tx_start,
  input  logic [TW-1:0] ichirp_cfg,
  input  logic [TW-1:0] iburst_cfg,
  input  logic          take_ichirp,
  input  logic          take_iburst,
  output logic [TW-1:0] eff_ichirp,
  output logic [TW-1:0] eff_iburst,
  output logic          viol_ichirp,
  output logic          viol_iburst
);
  localparam int unsigned GAP_LP_BASE = 6 * CYC_PER_US;
  localparam int unsigned GAP_BASE    = 4 * CYC_PER_US;
  localparam int unsigned GAP_FLOOR   = (31 * CYC_PER_US) / 10;
  localparam int unsigned BURST_MIN   = 95 * CYC_PER_US;

  int unsigned ic_min;
  logic        ic_short;
  logic        ib_short;

  always_comb begin
    ic_min     = chirp_gap_min(lp_en, 32'(tx_start), GAP_LP_BASE, GAP_BASE, GAP_FLOOR);
    ic_short   = 32'(ichirp_cfg) < ic_min;
    ib_short   = 32'(iburst_cfg) < BURST_MIN;
    eff_ichirp = ic_short ? TW'(ic_min) : ichirp_cfg;
    eff_iburst = ib_short ? TW'(BURST_MIN) : iburst_cfg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_ichirp <= 1'b0;
      viol_iburst <= 1'b0;
    end else begin
      if (take_ichirp && ic_short) viol_ichirp <= 1'b1;
      if (take_iburst && ib_short) viol_iburst <= 1'b1;
    end
  end

  a_r4_viol_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    viol_ichirp |=> viol_ichirp);
  a_r5_viol_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    viol_iburst |=> viol_iburst);
  a_r4_gap_floor: assert property (@(posedge clk) disable iff (!rst_n)
    take_ichirp |-> (32'(eff_ichirp) >= GAP_FLOOR));
  a_r5_gap_floor: assert property (@(posedge clk) disable iff (!rst_n)
    take_iburst |-> (32'(eff_iburst) >= BURST_MIN));
endmodule

// File: rtl/rfps_wake.sv
module rfps_wake #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          in_sleep,
  input  logic [TW-1:0] sleep_len,
  input  logic [3:0]    wake_evt,
  output logic          wake_fire,
  output logic [4:0]    wake_src
);
  logic [TW-1:0] scnt;
  logic          cnt_expired;
  logic [4:0]    causes;
  logic [4:0]    first_cause;

  always_comb begin
    cnt_expired = in_sleep && (scnt == '0);
    causes      = in_sleep ? {wake_evt, cnt_expired} : 5'b0;
    first_cause = causes & (~causes + 5'd1);
    wake_fire   = |causes;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scnt     <= '0;
      wake_src <= '0;
    end else begin
      if (arm)                         scnt <= (sleep_len == '0) ? '0 : sleep_len - 1'b1;
      else if (in_sleep && scnt != '0) scnt <= scnt - 1'b1;
      if (wake_fire) wake_src <= first_cause;
    end
  end

  a_r11_src_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wake_src));
  a_r10_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sleep && !wake_fire) |=> (scnt == $past(scnt) - 1'b1));
  a_r11_src_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wake_fire |=> $stable(wake_src));
endmodule

// File: rtl/rfps_seq.sv
module rfps_seq
  import rfps_pkg::*;
#(
  parameter int TW         = 16,
  parameter int CW         = 8,
  parameter int FW         = 20,
  parameter int CYC_PER_US = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_lp_en,
  input  logic [TW-1:0] cfg_tx_start,
  input  logic [TW-1:0] cfg_chirp_len,
  input  logic [TW-1:0] cfg_ichirp_idle,
  input  logic [TW-1:0] cfg_iburst_idle,
  input  logic [TW-1:0] cfg_proc_len,
  input  logic [CW-1:0] cfg_chirps,
  input  logic [CW-1:0] cfg_bursts,
  input  logic [FW-1:0] cfg_frame_period,
  input  logic [TW-1:0] cfg_sleep_len,
  input  logic          sleep_req,
  input  logic          pd_done,
  input  logic          restore_done,
  input  logic [3:0]    wake_evt,
  output logic [2:0]    phase,
  output logic          frame_start,
  output logic          rf_on,
  output logic          rf_txrx_on,
  output logic          rf_xtal_on,
  output logic          fe_on,
  output logic          fe_dp_gate,
  output logic          fe_all_gate,
  output logic          app_on,
  output logic          app_xtal_clk,
  output logic          acc_on,
  output logic          acc_gate,
  output logic          aon_on,
  output logic          pd_start,
  output logic          restore_req,
  output logic [4:0]    wake_src,
  output logic          viol_ichirp,
  output logic          viol_iburst,
  output logic          frame_overrun
);
  localparam int unsigned   IFR_MIN  = 135 * CYC_PER_US;
  localparam logic [FW-1:0] IFR_LAST = FW'(IFR_MIN - 1);

  function automatic logic [TW-1:0] less1(input logic [TW-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  phase_e        st, st_nx;
  logic [TW-1:0] tmr, tmr_nx;
  logic [CW-1:0] cidx, bidx;
  logic [FW-1:0] fcnt, icnt;
  logic [TW-1:0] eff_ichirp, eff_iburst;
  logic          wake_fire;
  pwr_t          pwr;

  // Named internal events
  logic tmr_done, last_chirp, last_burst, gap_end;
  logic to_ichirp, to_iburst, to_proc, to_ifr;
  logic period_hit, late, idle_met;
  logic go_sleep, launch_ifr, launch_rst, launch;
  logic enter_sleep, in_pd, in_sleep;

  always_comb begin
    tmr_done    = (tmr == '0);
    last_chirp  = ({1'b0, cidx} + 1'b1) >= {1'b0, cfg_chirps};
    last_burst  = ({1'b0, bidx} + 1'b1) >= {1'b0, cfg_bursts};
    gap_end     = (st == PH_ICHIRP || st == PH_IBURST) && tmr_done;
    to_ichirp   = (st == PH_CHIRP) && tmr_done && !last_chirp;
    to_iburst   = (st == PH_CHIRP) && tmr_done && last_chirp && !last_burst;
    to_proc     = (st == PH_CHIRP) && tmr_done && last_chirp && last_burst;
    to_ifr      = (st == PH_PROC) && tmr_done;
    period_hit  = ({1'b0, fcnt} + 1'b1) >= {1'b0, cfg_frame_period};
    late        = ({1'b0, fcnt} + 1'b1) >  {1'b0, cfg_frame_period};
    idle_met    = icnt >= IFR_LAST;
    go_sleep    = (st == PH_IFRAME) && sleep_req;
    launch_ifr  = (st == PH_IFRAME) && !sleep_req && period_hit && idle_met;
    launch_rst  = (st == PH_RESTORE) && restore_done;
    launch      = launch_ifr || launch_rst;
    in_pd       = (st == PH_PDWAIT);
    in_sleep    = (st == PH_SLEEP);
    enter_sleep = in_pd && pd_done;
  end

  always_comb begin
    st_nx = st;
    unique case (st)
      PH_CHIRP:   if (to_ichirp) st_nx = PH_ICHIRP;
                  else if (to_iburst) st_nx = PH_IBURST;
                  else if (to_proc) st_nx = PH_PROC;
      PH_ICHIRP,
      PH_IBURST:  if (gap_end) st_nx = PH_CHIRP;
      PH_PROC:    if (to_ifr) st_nx = PH_IFRAME;
      PH_IFRAME:  if (go_sleep) st_nx = PH_PDWAIT;
                  else if (launch_ifr) st_nx = PH_CHIRP;
      PH_PDWAIT:  if (enter_sleep) st_nx = PH_SLEEP;
      PH_SLEEP:   if (wake_fire) st_nx = PH_RESTORE;
      PH_RESTORE: if (launch_rst) st_nx = PH_CHIRP;
      default:    st_nx = PH_IFRAME;
    endcase
  end

  always_comb begin
    if (launch || gap_end)  tmr_nx = less1(cfg_chirp_len);
    else if (to_ichirp)     tmr_nx = less1(eff_ichirp);
    else if (to_iburst)     tmr_nx = less1(eff_iburst);
    else if (to_proc)       tmr_nx = less1(cfg_proc_len);
    else if (!tmr_done)     tmr_nx = tmr - 1'b1;
    else                    tmr_nx = tmr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= PH_IFRAME;
      tmr           <= '0;
      cidx          <= '0;
      bidx          <= '0;
      fcnt          <= '0;
      icnt          <= '0;
      frame_overrun <= 1'b0;
    end else begin
      st  <= st_nx;
      tmr <= tmr_nx;
      if (launch)                         cidx <= '0;
      else if (st == PH_ICHIRP && gap_end) cidx <= cidx + 1'b1;
      else if (st == PH_IBURST && gap_end) cidx <= '0;
      if (launch)                         bidx <= '0;
      else if (st == PH_IBURST && gap_end) bidx <= bidx + 1'b1;
      if (launch)             fcnt <= '0;
      else if (~&fcnt)        fcnt <= fcnt + 1'b1;
      if (to_ifr)             icnt <= '0;
      else if (st == PH_IFRAME && ~&icnt) icnt <= icnt + 1'b1;
      if (launch_ifr && late) frame_overrun <= 1'b1;
    end
  end

  rfps_minchk #(.TW(TW), .CYC_PER_US(CYC_PER_US)) u_minchk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lp_en      (cfg_lp_en),
    .tx_start   (cfg_tx_start),
    .ichirp_cfg (cfg_ichirp_idle),
    .iburst_cfg (cfg_iburst_idle),
    .take_ichirp(to_ichirp),
    .take_iburst(to_iburst),
    .eff_ichirp (eff_ichirp),
    .eff_iburst (eff_iburst),
    .viol_ichirp(viol_ichirp),
    .viol_iburst(viol_iburst)
  );

  rfps_wake #(.TW(TW)) u_wake (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (enter_sleep),
    .in_sleep (in_sleep),
    .sleep_len(cfg_sleep_len),
    .wake_evt (wake_evt),
    .wake_fire(wake_fire),
    .wake_src (wake_src)
  );

  rfps_pwrmap u_pwrmap (.ph(st), .pwr(pwr));

  assign phase        = st;
  assign frame_start  = (st == PH_CHIRP) && (fcnt == '0);
  assign pd_start     = in_pd;
  assign restore_req  = (st == PH_RESTORE);
  assign rf_on        = pwr.rf_on;
  assign rf_txrx_on   = pwr.rf_txrx_on;
  assign rf_xtal_on   = pwr.rf_xtal_on;
  assign fe_on        = pwr.fe_on;
  assign fe_dp_gate   = pwr.fe_dp_gate;
  assign fe_all_gate  = pwr.fe_all_gate;
  assign app_on       = pwr.app_on;
  assign app_xtal_clk = pwr.app_xtal_clk;
  assign acc_on       = pwr.acc_on;
  assign acc_gate     = pwr.acc_gate;
  assign aon_on       = pwr.aon_on;

  a_r8_sleep_from_iframe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_pd) |-> $past(st == PH_IFRAME));
  a_r9_pd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pd && !pd_done) |=> in_pd);
  a_r12_restore_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PH_RESTORE && !restore_done) |=> (st == PH_RESTORE));
  a_r6_start_origin: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> ($past(st == PH_IFRAME) || $past(st == PH_RESTORE)));
  a_r7_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    frame_overrun |=> frame_overrun);
  a_r3_gap_then_chirp: assert property (@(posedge clk) disable iff (!rst_n)
    gap_end |=> (st == PH_CHIRP));
endmodule

// File: tb/tb_rfps_seq.sv
module tb_rfps_seq;
  localparam int TW = 16, CW = 8, FW = 20, CYC = 2;
  localparam int FLOOR_C = (31 * CYC) / 10;
  localparam int BURST_C = 95 * CYC;
  localparam int IFR_C   = 135 * CYC;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_lp_en;
  logic [TW-1:0] cfg_tx_start, cfg_chirp_len, cfg_ichirp_idle, cfg_iburst_idle, cfg_proc_len, cfg_sleep_len;
  logic [CW-1:0] cfg_chirps, cfg_bursts;
  logic [FW-1:0] cfg_frame_period;
  logic sleep_req = 1'b0, pd_done = 1'b0, restore_done = 1'b0;
  logic [3:0] wake_evt = 4'b0;
  logic [2:0] phase;
  logic frame_start, rf_on, rf_txrx_on, rf_xtal_on, fe_on, fe_dp_gate, fe_all_gate;
  logic app_on, app_xtal_clk, acc_on, acc_gate, aon_on, pd_start, restore_req;
  logic [4:0] wake_src;
  logic viol_ichirp, viol_iburst, frame_overrun;

  int n_chk = 0, n_bad = 0, cyc = 0, run = 0;
  int last_len [8];
  logic [2:0] prev_ph = 3'd4;

  always #10 clk = ~clk; // 20-unit period, 50 MHz at 1 ns units

  rfps_seq #(.TW(TW), .CW(CW), .FW(FW), .CYC_PER_US(CYC)) dut (.*);

  // Phase run-length monitor, sampled on the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (phase != prev_ph) begin
        last_len[prev_ph] = run;
        run = 1;
        prev_ph = phase;
      end else run++;
    end
  end

  function automatic logic [10:0] exp_pwr(input logic [2:0] ph);
    case (ph)
      3'd0: return 11'b11110010111;
      3'd1: return 11'b10111010101;
      3'd2: return 11'b00111010111;
      3'd3: return 11'b00100010101;
      3'd6: return 11'b00000000001;
      default: return 11'b00111111001;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic chk_pwr(input string req);
    chk(req, {rf_on, rf_txrx_on, rf_xtal_on, fe_on, fe_dp_gate, fe_all_gate,
              app_on, app_xtal_clk, acc_on, acc_gate, aon_on}, exp_pwr(phase));
  endtask

  task automatic wait_phase(input logic [2:0] p);
    while (phase != p) tick();
  endtask

  task automatic wait_fs();
    do tick(); while (!frame_start);
  endtask

  task automatic measure_frame(output int n);
    n = 0;
    do begin tick(); n++; end while (!frame_start);
    tick(); tick();
  endtask

  task automatic t_reset();
    chk("R1 phase", phase, 4);
    chk("R1 flags", {wake_src, viol_ichirp, viol_iburst, frame_overrun, pd_start, restore_req}, 0);
    chk_pwr("R1 power");
  endtask

  task automatic t_power_map();
    wait_phase(3'd0); chk_pwr("R2 chirp");
    wait_phase(3'd1); chk_pwr("R2 chirp gap");
    wait_phase(3'd2); chk_pwr("R2 burst gap");
    wait_phase(3'd3); chk_pwr("R2 processing");
    wait_phase(3'd4); chk_pwr("R2 interframe");
  endtask

  task automatic t_frame_timing();
    int n;
    wait_fs();
    measure_frame(n);
    chk("R6 frame period", n, 800);
    chk("R3 chirp len", last_len[0], 10);
    chk("R3 chirp gap", last_len[1], 20);
    chk("R3 burst gap", last_len[2], 200);
    chk("R3 proc len", last_len[3], 30);
    chk("R6 idle len", last_len[4], 800 - 370);
    chk("R4 R5 no violation", {viol_ichirp, viol_iburst, frame_overrun}, 0);
  endtask

  task automatic t_ichirp_min(input logic lp, input int tx, input int exp);
    wait_phase(3'd4);
    cfg_lp_en = lp; cfg_tx_start = TW'(tx); cfg_ichirp_idle = 2;
    wait_fs();
    wait_phase(3'd4); tick();
    chk("R4 chirp gap min", last_len[1], exp);
    chk("R4 violation flag", viol_ichirp, 1);
  endtask

  task automatic t_iburst_min();
    wait_phase(3'd4);
    cfg_lp_en = 1'b1; cfg_tx_start = 2; cfg_ichirp_idle = 20; cfg_iburst_idle = 5;
    wait_fs();
    wait_phase(3'd4); tick();
    chk("R5 burst gap min", last_len[2], BURST_C);
    chk("R5 violation flag", viol_iburst, 1);
  endtask

  task automatic t_overrun();
    int n;
    wait_phase(3'd4);
    cfg_iburst_idle = 200; cfg_frame_period = 400;
    wait_fs();
    measure_frame(n);
    chk("R7 overrun frame length", n, 370 + IFR_C);
    chk("R7 overrun flag", frame_overrun, 1);
    cfg_frame_period = 800;
  endtask

  task automatic t_sleep_handshake();
    wait_phase(3'd4);
    sleep_req = 1'b1; tick(); sleep_req = 1'b0;
    chk("R8 enter pd wait", phase, 5);
    chk("R9 pd_start", pd_start, 1);
    chk_pwr("R2 pd wait");
    tick(); tick(); tick();
    chk("R9 hold without pd_done", phase, 5);
    pd_done = 1'b1; tick(); pd_done = 1'b0;
    chk("R9 sleep entered", phase, 6);
    chk_pwr("R2 sleep");
    tick(); tick();
    wake_evt = 4'b0101; tick(); wake_evt = 4'b0;
    chk("R10 wake to restore", phase, 7);
    chk("R11 priority uart over gpio", wake_src, 5'b00010);
    chk("R12 restore_req", restore_req, 1);
    chk_pwr("R2 restore");
    tick(); tick();
    chk("R12 hold without done", phase, 7);
    restore_done = 1'b1; tick(); restore_done = 1'b0;
    chk("R12 new frame phase", phase, 0);
    chk("R12 frame_start", frame_start, 1);
  endtask

  task automatic t_sleep_counter();
    int n;
    wait_phase(3'd4);
    sleep_req = 1'b1; tick(); sleep_req = 1'b0;
    pd_done = 1'b1; tick(); pd_done = 1'b0;
    n = 1;
    while (phase == 3'd6 && n < 1000) begin tick(); n++; end
    n--;
    chk("R10 sleep counter length", n, 50);
    chk("R11 counter source", wake_src, 5'b00001);
    restore_done = 1'b1; tick(); restore_done = 1'b0;
  endtask

  task automatic t_ignore();
    int bad = 0;
    sleep_req = 1'b1; wake_evt = 4'b1000; pd_done = 1'b1; restore_done = 1'b1;
    tick(); tick(); tick();
    sleep_req = 1'b0; wake_evt = 4'b0; pd_done = 1'b0; restore_done = 1'b0;
    while (phase != 3'd4) begin
      if (phase >= 3'd5) bad++;
      tick();
    end
    chk("R8 sleep_req ignored while active", bad, 0);
    chk("R10 wake ignored while active", wake_src, 5'b00001);
    wake_evt = 4'b1111; pd_done = 1'b1; restore_done = 1'b1;
    tick(); tick(); tick();
    wake_evt = 4'b0; pd_done = 1'b0; restore_done = 1'b0;
    chk("R10 wake ignored in idle", phase, 4);
    chk("R11 source unchanged", wake_src, 5'b00001);
  endtask

  task automatic t_coincide();
    wait_fs();
    repeat (799) tick();
    chk("R6 last idle cycle", phase, 4);
    sleep_req = 1'b1; tick(); sleep_req = 1'b0;
    chk("R8 sleep wins over launch", phase, 5);
    chk("R8 no frame_start", frame_start, 0);
    pd_done = 1'b1; tick(); pd_done = 1'b0;
    wake_evt = 4'b1000; tick(); wake_evt = 4'b0;
    chk("R11 rtc source", wake_src, 5'b10000);
    restore_done = 1'b1; tick(); restore_done = 1'b0;
    chk("R12 frame after restore", frame_start, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    cfg_lp_en = 1'b1; cfg_tx_start = 2; cfg_chirp_len = 10; cfg_ichirp_idle = 20;
    cfg_iburst_idle = 200; cfg_proc_len = 30; cfg_chirps = 3; cfg_bursts = 2;
    cfg_frame_period = 800; cfg_sleep_len = 50;
    repeat (5) @(posedge clk);
    #2 rst_n = 1'b1;
    t_reset();
    t_power_map();
    t_frame_timing();
    t_ichirp_min(1'b1, 3, 12 - 3);
    t_ichirp_min(1'b0, 3, FLOOR_C);
    t_ichirp_min(1'b0, 0, 8);
    t_ichirp_min(1'b1, 20, FLOOR_C);
    t_iburst_min();
    t_overrun();
    t_sleep_handshake();
    t_sleep_counter();
    t_ignore();
    t_coincide();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule